// File: doc/BRIEF.md
# Boundary Scan Data Register Chain

This block is the boundary data register of a test port. It places a scan cell at every device pin: one per input pin, one per output pin for its data, and one per output enable. The cells form one serial chain. Each cell has a shift stage clocked on the rising test clock and an update latch loaded on the falling test clock. The test port controller supplies the capture, shift and update strobes and a decoded mode code. The block then passes core signals straight to the pins, drives the pins from the latches, feeds the latches into the core, or turns every output driver off.

The chain is ordered from `scan_out` back to `scan_in`. First come the input cells, pin 0 nearest `scan_out`. Next come the output data cells, pin 0 first. Last come the enable cells. With the default parameters, bit i of a vector that is shifted in or out is defined as follows. Bits 0..NUM_IN-1 are the input pins. The next NUM_OUT bits are the output data bits. The top NUM_OUT bits are the output enables. The enable cells can also be built as a single shared cell that gates all outputs.

Top module: `bscan_chain`

## Requirements
- R1: While `shift_en` is high, each rising `tck` moves the chain one stage toward `scan_out`. `scan_in` enters the last enable cell, and `scan_out` shows input cell 0. A vector shifted in bit 0 first comes out bit 0 first after NUM_IN+2*NUM_OUT further shifts.
- R2: While `capture_en` is high, a rising `tck` loads the cells in parallel. Input cells load `pin_in`, except in INTEST where they keep their value. Output data and enable cells load `core_out`/`core_oe`, except in EXTEST where they keep their value. `capture_en` and `shift_en` are never high together.
- R3: The update latches load from the shift stages only on a falling `tck` while `update_en` is high. Shifting and capture leave latch-driven pins unchanged.
- R4: Mode code 0 (functional) and the unused codes 5..7 tie `pin_out`=`core_out`, `pin_oe`=`core_oe` and `core_in`=`pin_in` combinationally.
- R5: Mode code 1 (sample/preload) keeps the functional connections of R4 while the chain captures and updates. Latches preloaded in this mode drive the pins once EXTEST is selected.
- R6: Mode code 2 (EXTEST) drives `pin_out` from the output data latches and `pin_oe` from the enable latches. `core_in` still follows `pin_in`.
- R7: Mode code 3 (INTEST) drives `core_in` from the input cell latches, holds `pin_oe` at zero, and lets `pin_out` follow `core_out`.
- R8: Mode code 4 (float) forces every `pin_oe` bit to zero. `pin_out` follows `core_out` and `core_in` follows `pin_in`.
- R9: A low `trst_n` clears every shift stage and every update latch at once, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| mode | input | 3 | Decoded instruction mode code (0..4 used) |
| capture_en | input | 1 | Parallel capture strobe (capture state) |
| shift_en | input | 1 | Serial shift strobe (shift state) |
| update_en | input | 1 | Latch update strobe (update state) |
| scan_in | input | 1 | Serial data into the chain |
| scan_out | output | 1 | Serial data out of the chain |
| core_out | input | NUM_OUT | Output data from the core |
| core_oe | input | NUM_OUT | Output enables from the core |
| core_in | output | NUM_IN | Input data delivered to the core |
| pin_in | input | NUM_IN | Values seen at the input pins |
| pin_out | output | NUM_OUT | Data to the output pin drivers |
| pin_oe | output | NUM_OUT | Enables to the output pin drivers |

## Verification
Assertions check several properties on every clock. Each cell's single-step shift and its capture load or hold are checked, as is the rule that a latch only changes after an update strobe. The functional, float and INTEST pin connections are checked against the mode code, along with exclusive use of the capture and shift strobes. Other behaviour can only be shown by the bench's scenarios. These are the end-to-end bit order through the whole chain, and a preload in sample mode appearing at the pins after a switch to EXTEST. They also cover pins that stay steady through a full shift, the mixed capture/hold pattern under EXTEST and INTEST, and the asynchronous clear.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

   typedef enum logic [2:0] {
      BS_FUNC   = 3'd0,
      BS_SAMPLE = 3'd1,
      BS_EXTEST = 3'd2,
      BS_INTEST = 3'd3,
      BS_FLOAT  = 3'd4
   } bs_mode_e;

   // Steering derived from the mode code
   typedef struct packed {
      logic in_load;        // input cells take pin_in on capture
      logic out_load;       // output/enable cells take core values on capture
      logic pins_from_test; // pins driven by update latches
      logic pins_off;       // all output enables forced low
      logic core_from_test; // core inputs driven by update latches
   } bs_ctrl_t;

   function automatic bs_ctrl_t bs_decode(input logic [2:0] code);
      bs_ctrl_t c;
      c = '{in_load: 1'b1, out_load: 1'b1, pins_from_test: 1'b0,
            pins_off: 1'b0, core_from_test: 1'b0};
      case (code)
         BS_EXTEST: begin
            c.out_load       = 1'b0;
            c.pins_from_test = 1'b1;
         end
         BS_INTEST: begin
            c.in_load        = 1'b0;
            c.pins_off       = 1'b1;
            c.core_from_test = 1'b1;
         end
         BS_FLOAT: c.pins_off = 1'b1;
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/bsc_cell.sv
`timescale 1ns/1ps
module bsc_cell (
   input  logic tck,
   input  logic trst_n,
   input  logic capture_en,
   input  logic shift_en,
   input  logic update_en,
   input  logic load_en,
   input  logic par_in,
   input  logic ser_in,
   output logic ser_out,
   output logic upd_out
);

   logic cap_q;
   logic upd_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         cap_q <= 1'b0;
      end else if (capture_en) begin
         if (load_en) cap_q <= par_in;
      end else if (shift_en) begin
         cap_q <= ser_in;
      end
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)        upd_q <= 1'b0;
      else if (update_en) upd_q <= cap_q;
   end

   assign ser_out = cap_q;
   assign upd_out = upd_q;

   p_shift_step_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (shift_en && !capture_en) |=> (ser_out == $past(ser_in)));

   p_capture_load_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (capture_en && load_en) |=> (ser_out == $past(par_in)));

   p_capture_hold_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (capture_en && !load_en) |=> $stable(ser_out));

   p_latch_hold_r3: assert property (@(posedge tck) disable iff (!trst_n)
      !update_en |-> $stable(upd_out));

endmodule

// File: rtl/bsc_group.sv
`timescale 1ns/1ps
module bsc_group #(
   parameter int WIDTH = 4
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             capture_en,
   input  logic             shift_en,
   input  logic             update_en,
   input  logic             load_en,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic             ser_out,
   output logic [WIDTH-1:0] upd_out
);

   // link[k] is the serial output of cell k; cell 0 leaves the group first
   logic [WIDTH:0] link;

   assign link[WIDTH] = ser_in;
   assign ser_out     = link[0];

   for (genvar k = 0; k < WIDTH; k++) begin : g_cell
      bsc_cell u_cell (
         .tck        (tck),
         .trst_n     (trst_n),
         .capture_en (capture_en),
         .shift_en   (shift_en),
         .update_en  (update_en),
         .load_en    (load_en),
         .par_in     (par_in[k]),
         .ser_in     (link[k+1]),
         .ser_out    (link[k]),
         .upd_out    (upd_out[k])
      );
   end

endmodule

// File: rtl/bsc_mode_dec.sv
`timescale 1ns/1ps
module bsc_mode_dec
   import bscan_pkg::*;
(
   input  logic [2:0] mode,
   output bs_ctrl_t   ctrl
);

   always_comb ctrl = bs_decode(mode);

endmodule

// File: rtl/bsc_pin_mux.sv
`timescale 1ns/1ps
module bsc_pin_mux
   import bscan_pkg::*;
#(
   parameter int NUM_OUT = 4,
   parameter int NUM_IN  = 4
) (
   input  bs_ctrl_t           ctrl,
   input  logic [NUM_OUT-1:0] core_out,
   input  logic [NUM_OUT-1:0] core_oe,
   input  logic [NUM_OUT-1:0] out_test,
   input  logic [NUM_OUT-1:0] oe_test,
   input  logic [NUM_IN-1:0]  pin_in,
   input  logic [NUM_IN-1:0]  in_test,
   output logic [NUM_OUT-1:0] pin_out,
   output logic [NUM_OUT-1:0] pin_oe,
   output logic [NUM_IN-1:0]  core_in
);

   always_comb begin
      pin_out = ctrl.pins_from_test ? out_test : core_out;
      if (ctrl.pins_off)            pin_oe = '0;
      else if (ctrl.pins_from_test) pin_oe = oe_test;
      else                          pin_oe = core_oe;
      core_in = ctrl.core_from_test ? in_test : pin_in;
   end

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain
   import bscan_pkg::*;
#(
   parameter int NUM_OUT    = 4,
   parameter int NUM_IN     = 4,
   parameter bit OE_PER_PIN = 1'b1
) (
   input  logic               tck,
   input  logic               trst_n,
   input  logic [2:0]         mode,
   input  logic               capture_en,
   input  logic               shift_en,
   input  logic               update_en,
   input  logic               scan_in,
   output logic               scan_out,
   input  logic [NUM_OUT-1:0] core_out,
   input  logic [NUM_OUT-1:0] core_oe,
   output logic [NUM_IN-1:0]  core_in,
   input  logic [NUM_IN-1:0]  pin_in,
   output logic [NUM_OUT-1:0] pin_out,
   output logic [NUM_OUT-1:0] pin_oe
);

   localparam int OE_CELLS = OE_PER_PIN ? NUM_OUT : 1;

   if (NUM_OUT < 1) begin : g_bad_out
      $error("bscan_chain: NUM_OUT must be at least 1");
   end
   if (NUM_IN < 1) begin : g_bad_in
      $error("bscan_chain: NUM_IN must be at least 1");
   end

   bs_ctrl_t             ctrl;
   logic                 out_so;
   logic                 oe_so;
   logic [NUM_IN-1:0]    in_upd;
   logic [NUM_OUT-1:0]   out_upd;
   logic [OE_CELLS-1:0]  oe_upd;
   logic [OE_CELLS-1:0]  oe_par;
   logic [NUM_OUT-1:0]   oe_test;

   bsc_mode_dec u_dec (
      .mode (mode),
      .ctrl (ctrl)
   );

   // Enable cells: one per output pin, or one shared cell for all outputs
   if (OE_PER_PIN) begin : g_oe_each
      assign oe_par  = core_oe;
      assign oe_test = oe_upd;
   end else begin : g_oe_shared
      assign oe_par  = |core_oe;
      assign oe_test = {NUM_OUT{oe_upd[0]}};
   end

   bsc_group #(.WIDTH(OE_CELLS)) u_oe_grp (
      .tck        (tck),
      .trst_n     (trst_n),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .load_en    (ctrl.out_load),
      .par_in     (oe_par),
      .ser_in     (scan_in),
      .ser_out    (oe_so),
      .upd_out    (oe_upd)
   );

   bsc_group #(.WIDTH(NUM_OUT)) u_out_grp (
      .tck        (tck),
      .trst_n     (trst_n),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .load_en    (ctrl.out_load),
      .par_in     (core_out),
      .ser_in     (oe_so),
      .ser_out    (out_so),
      .upd_out    (out_upd)
   );

   bsc_group #(.WIDTH(NUM_IN)) u_in_grp (
      .tck        (tck),
      .trst_n     (trst_n),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .load_en    (ctrl.in_load),
      .par_in     (pin_in),
      .ser_in     (out_so),
      .ser_out    (scan_out),
      .upd_out    (in_upd)
   );

   bsc_pin_mux #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_mux (
      .ctrl     (ctrl),
      .core_out (core_out),
      .core_oe  (core_oe),
      .out_test (out_upd),
      .oe_test  (oe_test),
      .pin_in   (pin_in),
      .in_test  (in_upd),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .core_in  (core_in)
   );

   p_strobes_excl_r2: assert property (@(posedge tck) disable iff (!trst_n)
      !(capture_en && shift_en));

   p_func_pass_r4: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == 3'd0 || mode > 3'd4) |->
         (pin_out == core_out && pin_oe == core_oe && core_in == pin_in));

   p_sample_pass_r5: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == 3'd1) |->
         (pin_out == core_out && pin_oe == core_oe && core_in == pin_in));

   p_intest_isolate_r7: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == 3'd3) |-> (pin_oe == '0 && pin_out == core_out));

   p_float_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == 3'd4) |->
         (pin_oe == '0 && pin_out == core_out && core_in == pin_in));

endmodule

// File: tb/bscan_chain_test.sv
`timescale 1ns/1ps
module bscan_chain_test;

   localparam int NO = 4;
   localparam int NI = 4;
   localparam int L  = NI + 2 * NO;

   logic          tck = 1'b0;
   logic          trst_n;
   logic [2:0]    mode;
   logic          capture_en, shift_en, update_en, scan_in;
   logic          scan_out;
   logic [NO-1:0] core_out, core_oe, pin_out, pin_oe;
   logic [NI-1:0] core_in, pin_in;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #2.5 tck = ~tck;

   bscan_chain #(.NUM_OUT(NO), .NUM_IN(NI), .OE_PER_PIN(1'b1)) uut (
      .tck(tck), .trst_n(trst_n), .mode(mode),
      .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
      .scan_in(scan_in), .scan_out(scan_out),
      .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge tck);
      #1;
   endtask

   task automatic do_capture();
      capture_en = 1'b1;
      tick();
      capture_en = 1'b0;
   endtask

   task automatic do_update();
      update_en = 1'b1;
      tick();
      update_en = 1'b0;
   endtask

   task automatic shift_vec(input logic [L-1:0] v, output logic [L-1:0] got);
      for (int i = 0; i < L; i++) begin
         scan_in  = v[i];
         shift_en = 1'b1;
         got[i]   = scan_out;
         tick();
      end
      shift_en = 1'b0;
      scan_in  = 1'b0;
   endtask

   // R9: state held in reset
   task automatic t_reset();
      logic [L-1:0] got;
      chk("R9 scan_out in reset", 32'(scan_out), 32'd0);
      tick(); tick();
      trst_n = 1'b1;
      tick();
      mode = 3'd2;
      #1;
      chk("R9 latched pin_oe after reset", 32'(pin_oe), 32'd0);
      chk("R9 latched pin_out after reset", 32'(pin_out), 32'd0);
      mode = 3'd0;
      shift_vec('0, got);
      chk("R9 chain empty after reset", 32'(got), 32'd0);
   endtask

   // R4: functional pass-through
   task automatic t_func();
      mode = 3'd0;
      core_out = 4'hA; core_oe = 4'h5; pin_in = 4'h3;
      #1;
      chk("R4 pin_out", 32'(pin_out), 32'hA);
      chk("R4 pin_oe", 32'(pin_oe), 32'h5);
      chk("R4 core_in", 32'(core_in), 32'h3);
      core_out = 4'h6; core_oe = 4'hF; pin_in = 4'hC;
      #1;
      chk("R4 pin_out second pattern", 32'(pin_out), 32'h6);
      chk("R4 core_in second pattern", 32'(core_in), 32'hC);
   endtask

   // R5, R2, R6: sample, preload, then EXTEST
   task automatic t_sample_preload(input logic [L-1:0] pre);
      logic [L-1:0] got;
      mode = 3'd1;
      pin_in = 4'h9; core_out = 4'h2; core_oe = 4'hD;
      do_capture();
      shift_vec(pre, got);
      chk("R2 sample snapshot", 32'(got), 32'({4'hD, 4'h2, 4'h9}));
      do_update();
      chk("R5 pins unchanged after preload", 32'({pin_oe, pin_out}), 32'({4'hD, 4'h2}));
      chk("R5 core_in unchanged", 32'(core_in), 32'h9);
      mode = 3'd2;
      #1;
      chk("R6 pin_out from preload", 32'(pin_out), 32'(pre[7:4]));
      chk("R6 pin_oe from preload", 32'(pin_oe), 32'(pre[11:8]));
      chk("R6 core_in follows pin", 32'(core_in), 32'h9);
   endtask

   // R1, R3: shifting under EXTEST leaves pins on the latches
   task automatic t_extest_shift(input logic [L-1:0] pre, input logic [L-1:0] nxt);
      logic [L-1:0] got;
      logic         moved;
      moved = 1'b0;
      mode = 3'd2;
      for (int i = 0; i < L; i++) begin
         scan_in  = nxt[i];
         shift_en = 1'b1;
         got[i]   = scan_out;
         tick();
         if ({pin_oe, pin_out} !== {pre[11:8], pre[7:4]}) moved = 1'b1;
      end
      shift_en = 1'b0;
      chk("R3 pins steady during shift", 32'(moved), 32'd0);
      chk("R1 shifted-out order", 32'(got), 32'(pre));
      do_update();
      chk("R3 pins after update", 32'({pin_oe, pin_out}), 32'({nxt[11:8], nxt[7:4]}));
   endtask

   // R2: EXTEST capture keeps output cells, loads input cells
   task automatic t_extest_capture(input logic [L-1:0] held);
      logic [L-1:0] got;
      mode = 3'd2;
      pin_in = 4'h6; core_out = 4'h1; core_oe = 4'h1;
      do_capture();
      shift_vec('0, got);
      chk("R2 EXTEST capture", 32'(got), 32'({held[11:4], 4'h6}));
   endtask

   // R7: INTEST
   task automatic t_intest(input logic [L-1:0] tv);
      logic [L-1:0] got;
      logic [L-1:0] junk;
      mode = 3'd2;
      shift_vec(tv, junk);
      do_update();
      mode = 3'd3;
      pin_in = 4'h0; core_out = 4'hB; core_oe = 4'h7;
      #1;
      chk("R7 core_in from latch", 32'(core_in), 32'(tv[3:0]));
      chk("R7 pin_oe off", 32'(pin_oe), 32'd0);
      chk("R7 pin_out follows core", 32'(pin_out), 32'hB);
      do_capture();
      shift_vec('0, got);
      chk("R2 INTEST capture", 32'(got), 32'({4'h7, 4'hB, tv[3:0]}));
   endtask

   // R8: float
   task automatic t_float();
      mode = 3'd4;
      core_out = 4'h5; core_oe = 4'hF; pin_in = 4'hE;
      #1;
      chk("R8 pin_oe off", 32'(pin_oe), 32'd0);
      chk("R8 pin_out follows core", 32'(pin_out), 32'h5);
      chk("R8 core_in follows pin", 32'(core_in), 32'hE);
   endtask

   // R4: unused code behaves as functional
   task automatic t_unused();
      mode = 3'd6;
      core_out = 4'h8; core_oe = 4'h3; pin_in = 4'h1;
      #1;
      chk("R4 unused code pin_oe", 32'(pin_oe), 32'h3);
      chk("R4 unused code core_in", 32'(core_in), 32'h1);
   endtask

   // R9: asynchronous clear mid-run
   task automatic t_async_reset();
      logic [L-1:0] junk;
      mode = 3'd2;
      shift_vec(12'hFFF, junk);
      do_update();
      chk("R9 latches loaded before clear", 32'(pin_oe), 32'hF);
      #1;
      trst_n = 1'b0;
      #0.5;
      chk("R9 async clear pin_oe", 32'(pin_oe), 32'd0);
      chk("R9 async clear scan_out", 32'(scan_out), 32'd0);
      tick();
      trst_n = 1'b1;
      tick();
   endtask

   initial begin
      trst_n = 1'b0; mode = 3'd0;
      capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0; scan_in = 1'b0;
      core_out = '0; core_oe = '0; pin_in = '0;
      #1;
      t_reset();
      t_func();
      t_sample_preload(12'h5A3);
      t_extest_shift(12'h5A3, 12'hC69);
      t_extest_capture(12'hC69);
      t_intest(12'h00B);
      t_float();
      t_unused();
      t_async_reset();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule